// File: doc/BRIEF.md
# Dual 12-Bit DAC Byte-Loaded Register Front End

This block is the digital register stage in front of a pair of 12-bit converters that are loaded over an 8-bit bus. Each channel owns a low-byte input register, a 4-bit high input register and a 12-bit output (DAC) register. A host writes a code in two bus writes: the low byte, then the upper four bits. The upper four bits are right-justified on the bus, so they come from the four lowest data lines. A separate update strobe copies the input registers of both channels into their output registers in the same clock cycle. This double buffering lets both converter codes change together.

All strobes are active low and come from an asynchronous host bus. They pass through a two-stage synchronizer in the system clock domain. A write takes effect on the rising (trailing) edge of the write strobe, using the chip select, update, address and data values that were present while write was low. An active-low clear input empties every register at once, with no clock needed. A synchronous active-high reset does the same at a clock edge.

Top module: `dual_dac_loader`

## Requirements
- R1: While `rst` is high at a clock edge, every register is set to zero, so `dac_code` reads 0 on the following cycle.
- R2: A write with `cs_n`=0 and address 0 (channel A) or 2 (channel B) loads `data[7:0]` into bits 7:0 of that channel's input code. Address bit 1 selects the channel (0=A, 1=B) and address bit 0 selects the part (0=low byte, 1=high bits).
- R3: A write with `cs_n`=0 and address 1 or 3 loads `data[3:0]` into bits 11:8 of that channel's input code. `data[7:4]` is ignored.
- R4: A write to an input register while `upd_n` is high leaves `dac_code` unchanged.
- R5: A write with `upd_n`=0 copies the input codes of both channels into `dac_code`. Channel A is `dac_code[11:0]` and channel B is `dac_code[23:12]`. Both channels change in the same clock cycle.
- R6: When `cs_n` and `upd_n` are both 0 in one write, the addressed input register is loaded. The transfer then carries that newly written value.
- R7: Nothing is loaded unless `wr_n` makes a low-to-high transition. A write pulse with `cs_n` and `upd_n` both high changes no register.
- R8: Taking `clr_n` low sets every input register and both output codes to zero at once, with no clock edge needed.
- R9: A write acts after `wr_n` rises. The output stays unchanged while `wr_n` is held low. It changes on the third clock edge after the rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Asynchronous clear of all registers, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; acts on its rising edge |
| upd_n | input | 1 | Transfer input registers to output registers, active low |
| addr | input | 2 | Register select: bit 1 is the channel, bit 0 is low byte or high bits |
| data | input | 8 | Bus data |
| dac_code | output | 24 | Held codes: channel A in 11:0, channel B in 23:12 |

## Verification
The bench tries three write patterns. The first loads input registers only. The second transfers without selecting a register. The third combines a load and a transfer in one write. Together they separate buffering from transfer and show whether the combined write forwards the fresh value. Every cycle during an update is sampled, which exposes any skew between the two channels. Nibble data with its upper bus bits set checks the right-justified placement. Three further patterns probe the edge and clear behaviour. A held-low write strobe and a deselected write pulse check edge triggering. A clear between writes, followed by a bare update, shows that the input registers were emptied as well.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
    localparam int BUS_W  = 8;
    localparam int HI_W   = 4;
    localparam int CODE_W = BUS_W + HI_W;
    localparam int NCH    = 2;
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int ADDR_W = CH_W + 1;
    localparam int SYNC_N = 2;

    typedef enum logic { PART_LO = 1'b0, PART_HI = 1'b1 } part_e;

    typedef struct packed {
        logic              wr_n;
        logic              cs_n;
        logic              upd_n;
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  data;
    } bus_t;

    typedef struct packed {
        logic             load;
        logic             xfer;
        logic [CH_W-1:0]  chan;
        part_e            part;
        logic [BUS_W-1:0] data;
    } cmd_t;

    localparam bus_t BUS_IDLE = '{wr_n: 1'b1, cs_n: 1'b1, upd_n: 1'b1,
                                  addr: '0, data: '0};

    function automatic logic [CH_W-1:0] addr_chan(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:1];
    endfunction

    function automatic part_e addr_part(input logic [ADDR_W-1:0] a);
        return part_e'(a[0]);
    endfunction
endpackage

// File: rtl/dacif_strobe.sv
module dacif_strobe
    import dacif_pkg::*;
#(
    parameter int STAGES = SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  bus_t bus_in,
    output cmd_t cmd
);
    bus_t stg [0:STAGES];
    logic wr_rise;

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= BUS_IDLE;
        else     stg[0] <= bus_in;
    end

    generate
        for (genvar k = 1; k <= STAGES; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[k] <= BUS_IDLE;
                else     stg[k] <= stg[k-1];
            end
        end
    endgenerate

    // rising edge: the oldest stage still low, the one before it now high
    assign wr_rise = !stg[STAGES].wr_n && stg[STAGES-1].wr_n;

    always_comb begin
        cmd.load = wr_rise && !stg[STAGES].cs_n;
        cmd.xfer = wr_rise && !stg[STAGES].upd_n;
        cmd.chan = addr_chan(stg[STAGES].addr);
        cmd.part = addr_part(stg[STAGES].addr);
        cmd.data = stg[STAGES].data;
    end
endmodule

// File: rtl/dacif_inreg.sv
module dacif_inreg
    import dacif_pkg::*;
#(
    parameter int CH = NCH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_n,
    input  cmd_t                 cmd,
    output logic [CH*CODE_W-1:0] in_cur,
    output logic [CH*CODE_W-1:0] in_next
);
    generate
        for (genvar c = 0; c < CH; c++) begin : g_ch
            logic [BUS_W-1:0] lo_q, lo_d;
            logic [HI_W-1:0]  hi_q, hi_d;
            logic             hit;

            assign hit = cmd.load && (cmd.chan == CH_W'(c));

            always_comb begin
                lo_d = lo_q;
                hi_d = hi_q;
                if (hit && cmd.part == PART_LO) lo_d = cmd.data;
                if (hit && cmd.part == PART_HI) hi_d = cmd.data[HI_W-1:0];
            end

            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    lo_q <= '0;
                    hi_q <= '0;
                end else if (rst) begin
                    lo_q <= '0;
                    hi_q <= '0;
                end else begin
                    lo_q <= lo_d;
                    hi_q <= hi_d;
                end
            end

            assign in_cur[c*CODE_W +: CODE_W]  = {hi_q, lo_q};
            assign in_next[c*CODE_W +: CODE_W] = {hi_d, lo_d};
        end
    endgenerate
endmodule

// File: rtl/dacif_dacreg.sv
module dacif_dacreg
    import dacif_pkg::*;
#(
    parameter int CH = NCH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_n,
    input  logic                 xfer,
    input  logic [CH*CODE_W-1:0] in_next,
    output logic [CH*CODE_W-1:0] dac_code
);
    generate
        for (genvar c = 0; c < CH; c++) begin : g_ch
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)    dac_code[c*CODE_W +: CODE_W] <= '0;
                else if (rst)  dac_code[c*CODE_W +: CODE_W] <= '0;
                else if (xfer) dac_code[c*CODE_W +: CODE_W] <= in_next[c*CODE_W +: CODE_W];
            end
        end
    endgenerate
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
    import dacif_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr_n,
    input  logic                  cs_n,
    input  logic                  wr_n,
    input  logic                  upd_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [BUS_W-1:0]      data,
    output logic [NCH*CODE_W-1:0] dac_code
);
    bus_t                  bus_in;
    cmd_t                  cmd;
    logic [NCH*CODE_W-1:0] in_cur;
    logic [NCH*CODE_W-1:0] in_next;
    logic                  ld_evt;
    logic                  xf_evt;

    assign bus_in = '{wr_n: wr_n, cs_n: cs_n, upd_n: upd_n, addr: addr, data: data};
    assign ld_evt = cmd.load;
    assign xf_evt = cmd.xfer;

    dacif_strobe #(.STAGES(SYNC_N)) u_strobe (
        .clk    (clk),
        .rst    (rst),
        .bus_in (bus_in),
        .cmd    (cmd)
    );

    dacif_inreg #(.CH(NCH)) u_inreg (
        .clk     (clk),
        .rst     (rst),
        .clr_n   (clr_n),
        .cmd     (cmd),
        .in_cur  (in_cur),
        .in_next (in_next)
    );

    dacif_dacreg #(.CH(NCH)) u_dacreg (
        .clk      (clk),
        .rst      (rst),
        .clr_n    (clr_n),
        .xfer     (xf_evt),
        .in_next  (in_next),
        .dac_code (dac_code)
    );
endmodule

// File: rtl/dacif_chk.sv
module dacif_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst,
    input logic         clr_n,
    input logic         ld_evt,
    input logic         xf_evt,
    input logic [W-1:0] in_cur,
    input logic [W-1:0] dac_code
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
        rst |=> (dac_code == '0));

    // R4
    hold_without_xfer_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        !xf_evt |=> $stable(dac_code));

    // R5
    xfer_copies_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (xf_evt && !ld_evt) |=> (dac_code == $past(in_cur)));

    // R7
    no_load_stable_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        !ld_evt |=> $stable(in_cur));

    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (dac_code == '0 && in_cur == '0));
endmodule

bind dual_dac_loader dacif_chk #(.W(dacif_pkg::NCH * dacif_pkg::CODE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr_n    (clr_n),
    .ld_evt   (ld_evt),
    .xf_evt   (xf_evt),
    .in_cur   (in_cur),
    .dac_code (dac_code)
);

// File: tb/tb_dual_dac_loader.sv
module tb_dual_dac_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        upd_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [7:0]  data = '0;
    logic [23:0] dac_code;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    dual_dac_loader dut (
        .clk(clk), .rst(rst), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
        .upd_n(upd_n), .addr(addr), .data(data), .dac_code(dac_code)
    );

    task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // one complete bus write: strobe low for 3 edges, rise, then settle
    task automatic bus_write(input logic cs, input logic upd, input logic [1:0] a,
                             input logic [7:0] d);
        cs_n = cs; upd_n = upd; addr = a; data = d; wr_n = 1'b0;
        tick(3);
        wr_n = 1'b1;
        tick(4);
        cs_n = 1'b1; upd_n = 1'b1;
        tick(1);
    endtask

    task automatic t_reset();
        chk("R1 reset clears outputs", dac_code, 24'h000000);
    endtask

    task automatic t_low_byte();
        bus_write(1'b0, 1'b1, 2'd0, 8'h5A);
        chk("R4 input write leaves output", dac_code, 24'h000000);
        bus_write(1'b1, 1'b0, 2'd0, 8'h00);
        chk("R2 low byte channel A", dac_code, 24'h00005A);
    endtask

    task automatic t_high_bits();
        bus_write(1'b0, 1'b1, 2'd1, 8'hF3);
        chk("R4 high write leaves output", dac_code, 24'h00005A);
        bus_write(1'b1, 1'b0, 2'd0, 8'h00);
        chk("R3 high bits from data[3:0]", dac_code, 24'h00035A);
    endtask

    task automatic t_both_update();
        logic [11:0] pa, pb;
        int skew = 0;
        bus_write(1'b0, 1'b1, 2'd2, 8'hC7);
        bus_write(1'b0, 1'b1, 2'd3, 8'h69);
        bus_write(1'b0, 1'b1, 2'd0, 8'h11);
        chk("R4 three buffered writes", dac_code, 24'h00035A);
        cs_n = 1'b1; upd_n = 1'b0; wr_n = 1'b0;
        tick(3);
        wr_n = 1'b1;
        pa = dac_code[11:0]; pb = dac_code[23:12];
        for (int i = 0; i < 6; i++) begin
            tick(1);
            if ((dac_code[11:0] != pa) != (dac_code[23:12] != pb)) skew++;
            pa = dac_code[11:0]; pb = dac_code[23:12];
        end
        upd_n = 1'b1;
        tick(1);
        chk("R5 channels skew cycles", 24'(skew), 24'd0);
        chk("R5 both channels updated", dac_code, 24'h9C7311);
    endtask

    task automatic t_combined();
        bus_write(1'b0, 1'b0, 2'd3, 8'h0E);
        chk("R6 load with transfer", dac_code, 24'hEC7311);
    endtask

    task automatic t_no_strobe();
        cs_n = 1'b0; upd_n = 1'b0; addr = 2'd0; data = 8'hAA;
        tick(10);
        cs_n = 1'b1; upd_n = 1'b1;
        tick(1);
        chk("R7 no write edge no change", dac_code, 24'hEC7311);
        bus_write(1'b1, 1'b1, 2'd0, 8'hFF);
        bus_write(1'b1, 1'b0, 2'd0, 8'h00);
        chk("R7 deselected pulse ignored", dac_code, 24'hEC7311);
    endtask

    task automatic t_edge();
        cs_n = 1'b0; upd_n = 1'b0; addr = 2'd2; data = 8'h44; wr_n = 1'b0;
        tick(6);
        chk("R9 held low no change", dac_code, 24'hEC7311);
        wr_n = 1'b1;
        tick(1);
        chk("R9 unchanged after edge 1", dac_code, 24'hEC7311);
        tick(1);
        chk("R9 unchanged after edge 2", dac_code, 24'hEC7311);
        tick(1);
        chk("R9 changed after edge 3", dac_code, 24'hE44311);
        cs_n = 1'b1; upd_n = 1'b1;
        tick(2);
    endtask

    task automatic t_clear();
        bus_write(1'b0, 1'b1, 2'd1, 8'h07);
        clr_n = 1'b0;
        #1;
        chk("R8 clear without clock", dac_code, 24'h000000);
        tick(2);
        clr_n = 1'b1;
        tick(1);
        bus_write(1'b1, 1'b0, 2'd0, 8'h00);
        chk("R8 input registers emptied", dac_code, 24'h000000);
        bus_write(1'b0, 1'b0, 2'd1, 8'h02);
        chk("R3 write after clear", dac_code, 24'h000200);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_low_byte();
        t_high_bits();
        t_both_update();
        t_combined();
        t_no_strobe();
        t_edge();
        t_clear();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule